// File: doc/BRIEF.md
# Split/Cascade Timer with Variable-Width PWM

This block is a timer built from two 8-bit counting halves. Software picks one of four arrangements. In the first, the halves count as two independent timers. In the second, the low half stays a timer and the high half drives a fixed 256-step pulse-width modulator. In the third, the halves join into one 16-bit timer. In the fourth, the joined counter drives a pulse-width modulator whose period is a power of two, with a width chosen from 9 to 16 bits. Every period end raises a one-clock pulse on the low-half or high-half interrupt line. The system combines the two lines into one request.

The basic count step is one timer cycle, which lasts two clocks. In the two joined arrangements, a fine-resolution select makes the counter step on every clock, which halves the step time. The PWM output is high from the start of each period while the count is below the held duty value. Duty and width values are captured when counting starts and again at each period boundary, so the output never shows a partial update.

Top module: `splitTimerPwm`

## Requirements
- R1: While `start` is low, or after reset, the counters are cleared and `pwmOut`, `loIrq` and `hiIrq` are low. They stay low until `start` has been seen high.
- R2: With `fineRes` low, or in modes 0 and 1, the counters advance once every two clocks. An interrupt pulse therefore never lasts two consecutive clocks.
- R3: In modes 2 and 3 with `fineRes` high, the joined counter advances on every clock.
- R4: Mode 0 (`mode`=0): the low half counts 0..`periodVal[7:0]` and the high half counts 0..`periodVal[15:8]`. Each half wraps on its own and pulses its own interrupt (`loIrq` or `hiIrq`) when it wraps, so the two pulse spacings are 2*(limit+1) clocks each.
- R5: Mode 1: the low half is a timer as in R4. The high half counts 256 steps per period and pulses `hiIrq` at each period end. `pwmOut` is high while the high-half count is below `dutyVal[7:0]`, so over 512 clocks `pwmOut` is high for 2*`dutyVal[7:0]` clocks.
- R6: Mode 2: the 16-bit count runs 0..`periodVal` and pulses `hiIrq` at each wrap. `loIrq` stays low.
- R7: Mode 3: the period is 2^(9+`widthSel`) steps and `hiIrq` pulses at each period end. `pwmOut` is high while the 16-bit count is below the held duty value.
- R8: In modes 1 and 3, a change to `dutyVal` or `widthSel` during a run takes effect only at the next period boundary. The period that is under way keeps the old values.
- R9: A duty value of 0 keeps `pwmOut` low for the whole period. In mode 3, a duty value equal to or above the period keeps `pwmOut` high for the whole period.
- R10: `pwmOut` stays low in modes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run enable; low clears the counters and loads the duty and width values |
| mode | input | 2 | 0 split timers, 1 timer plus 8-bit PWM, 2 joined timer, 3 variable-width PWM |
| fineRes | input | 1 | Step on every clock in modes 2 and 3 |
| periodVal | input | 16 | Timer limits: low byte for the low half, high byte for the high half, all 16 bits in mode 2 |
| dutyVal | input | 16 | PWM duty: low byte in mode 1, all 16 bits in mode 3 |
| widthSel | input | 3 | PWM width in mode 3: 9 + widthSel bits |
| pwmOut | output | 1 | PWM output |
| loIrq | output | 1 | One-clock pulse when the low half wraps |
| hiIrq | output | 1 | One-clock pulse when the high half or the joined counter reaches its period end |

## Verification
Each mode is run with directed limits and duty values and with values drawn at random. The bench measures interrupt spacing and the number of high PWM clocks per window, and compares them with closed-form results. Running the same limit with and without fine resolution shows whether the step rate doubles. In mode 0, unequal limits on the two halves show whether the halves wrap independently. Duty 0, duty at the period and duty far above it test the saturated ends of the output. A duty or width change applied right at a boundary shows whether the new value is used one period too early.

// File: rtl/splitTimerPwm_pkg.sv
package splitTimerPwm_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_TMR_PWM  = 2'd1,
    MODE_WIDE     = 2'd2,
    MODE_WIDE_PWM = 2'd3
  } timerMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clear;   // stopped: clear counters, load shadow values
    logic       step;    // advance the counters this clock
    logic       active;  // counting was enabled on the previous edge
    timerMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/splitTimerPwm_ctrl.sv
module splitTimerPwm_ctrl
  import splitTimerPwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  timerMode_e  mode,
  input  logic        fineRes,
  output ctrlStrobe_t strobe
);

  logic phase;
  logic activeQ;
  logic fineAllowed;

  // only the joined modes may step every clock
  assign fineAllowed = (mode == MODE_WIDE) || (mode == MODE_WIDE_PWM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      activeQ <= start;
      phase   <= start ? ~phase : 1'b0;
    end
  end

  always_comb begin
    strobe.clear  = !start;
    strobe.step   = start && ((fineAllowed && fineRes) || phase);
    strobe.active = activeQ;
    strobe.mode   = mode;
  end

endmodule

// File: rtl/splitTimerPwm_dp.sv
module splitTimerPwm_dp
  import splitTimerPwm_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int SEL_W  = $clog2(HALF_W),
  parameter int CNT_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CNT_W-1:0]  periodVal,
  input  logic [CNT_W-1:0]  dutyVal,
  input  logic [SEL_W-1:0]  widthSel,
  output logic              pwmOut,
  output logic              loIrq,
  output logic              hiIrq
);

  localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(HALF_W - 1);

  logic [HALF_W-1:0] cnt [2];          // [0] low half, [1] high half
  logic [HALF_W-1:0] halfLimit [2];
  logic [1:0]        halfHit;
  logic [CNT_W-1:0]  wide;
  logic [CNT_W-1:0]  dutyHeld;
  logic [SEL_W-1:0]  widthHeld;
  logic [SEL_W-1:0]  shiftAmt;
  logic [CNT_W-1:0]  wideMask;
  logic              wideHit;
  logic              pwm8End;
  logic              wideEnd;
  logic              pwmRaw;

  // per-half limit compare, same structure for both halves
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halfLimit[h] = periodVal[h*HALF_W +: HALF_W];
    assign halfHit[h]   = (cnt[h] == halfLimit[h]);
  end

  assign wide     = {cnt[1], cnt[0]};
  assign shiftAmt = TOP_SEL - widthHeld;
  assign wideMask = {CNT_W{1'b1}} >> shiftAmt;
  assign wideHit  = (wide == periodVal);
  assign wideEnd  = (wide == wideMask);
  assign pwm8End  = (cnt[1] == {HALF_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      dutyHeld  <= '0;
      widthHeld <= '0;
      loIrq     <= 1'b0;
      hiIrq     <= 1'b0;
    end else if (strobe.clear) begin
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      dutyHeld  <= dutyVal;
      widthHeld <= widthSel;
      loIrq     <= 1'b0;
      hiIrq     <= 1'b0;
    end else begin
      loIrq <= 1'b0;
      hiIrq <= 1'b0;
      if (strobe.step) begin
        case (strobe.mode)
          MODE_SPLIT: begin
            cnt[0] <= halfHit[0] ? '0 : cnt[0] + 1'b1;
            cnt[1] <= halfHit[1] ? '0 : cnt[1] + 1'b1;
            loIrq  <= halfHit[0];
            hiIrq  <= halfHit[1];
          end
          MODE_TMR_PWM: begin
            cnt[0] <= halfHit[0] ? '0 : cnt[0] + 1'b1;
            loIrq  <= halfHit[0];
            cnt[1] <= cnt[1] + 1'b1;
            hiIrq  <= pwm8End;
            if (pwm8End) dutyHeld <= dutyVal;
          end
          MODE_WIDE: begin
            {cnt[1], cnt[0]} <= wideHit ? '0 : wide + CNT_W'(1);
            hiIrq            <= wideHit;
          end
          default: begin
            {cnt[1], cnt[0]} <= wideEnd ? '0 : wide + CNT_W'(1);
            hiIrq            <= wideEnd;
            if (wideEnd) begin
              dutyHeld  <= dutyVal;
              widthHeld <= widthSel;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (strobe.mode)
      MODE_TMR_PWM:  pwmRaw = (cnt[1] < dutyHeld[HALF_W-1:0]);
      MODE_WIDE_PWM: pwmRaw = (wide < dutyHeld);
      default:       pwmRaw = 1'b0;
    endcase
  end

  assign pwmOut = strobe.active && pwmRaw;

endmodule

// File: rtl/splitTimerPwm.sv
module splitTimerPwm
  import splitTimerPwm_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int SEL_W  = $clog2(HALF_W),
  parameter int CNT_W  = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             fineRes,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] dutyVal,
  input  logic [SEL_W-1:0] widthSel,
  output logic             pwmOut,
  output logic             loIrq,
  output logic             hiIrq
);

  ctrlStrobe_t strobe;

  splitTimerPwm_ctrl ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mode    (timerMode_e'(mode)),
    .fineRes (fineRes),
    .strobe  (strobe)
  );

  splitTimerPwm_dp #(
    .HALF_W (HALF_W),
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W)
  ) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .periodVal (periodVal),
    .dutyVal   (dutyVal),
    .widthSel  (widthSel),
    .pwmOut    (pwmOut),
    .loIrq     (loIrq),
    .hiIrq     (hiIrq)
  );

endmodule

// File: rtl/splitTimerPwm_chk.sv
module splitTimerPwm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] mode,
  input logic       loIrq,
  input logic       hiIrq,
  input logic       pwmOut
);

  // R1: a stopped timer produces no output on the following cycle
  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (!pwmOut && !loIrq && !hiIrq));

  // R2: coarse stepping never yields back-to-back low-half pulses
  assert_no_double_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] == 1'b0 && $stable(mode) && loIrq) |=> !loIrq);

  // R6: the joined timer leaves the low-half pulse idle
  assert_wide_lo_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && $stable(mode)) |-> !loIrq);

  // R10: timer-only modes keep the PWM pin low
  assert_timer_no_pwm_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mode[0] == 1'b0) |-> !pwmOut);

endmodule

bind splitTimerPwm splitTimerPwm_chk chkInst (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .mode   (mode),
  .loIrq  (loIrq),
  .hiIrq  (hiIrq),
  .pwmOut (pwmOut)
);

// File: tb/splitTimerPwm_test.sv
`timescale 1ns/1ps
module splitTimerPwm_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        fineRes = 1'b0;
  logic [15:0] periodVal = '0;
  logic [15:0] dutyVal = '0;
  logic [2:0]  widthSel = '0;
  logic        pwmOut, loIrq, hiIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  splitTimerPwm uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .fineRes(fineRes),
    .periodVal(periodVal), .dutyVal(dutyVal), .widthSel(widthSel),
    .pwmOut(pwmOut), .loIrq(loIrq), .hiIrq(hiIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected number of high clocks over one mode-3 period
  function automatic int wideHighs(input int sel, input int duty, input bit fine);
    int per = 1 << (9 + sel);
    int h = (duty < per) ? duty : per;
    return fine ? h : 2 * h;
  endfunction

  task automatic setup(input logic [1:0] m, input bit f, input int per,
                       input int duty, input int sel);
    @(negedge clk);
    start = 1'b0;
    mode = m; fineRes = f;
    periodVal = 16'(per); dutyVal = 16'(duty); widthSel = 3'(sel);
    repeat (3) @(negedge clk);
    start = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic countHigh(input int n, output int k);
    k = 0;
    repeat (n) begin
      @(negedge clk);
      k += pwmOut;
    end
  endtask

  // leaves the caller at the negedge where the selected pulse is seen
  task automatic waitPulse(input bit sel, output bit ok);
    int t = 0;
    ok = 0;
    while (t < 5000) begin
      @(negedge clk);
      if ((sel ? hiIrq : loIrq) === 1'b1) begin ok = 1; break; end
      t++;
    end
  endtask

  task automatic nextGap(input bit sel, output int g);
    bit ok;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while ((sel ? hiIrq : loIrq) !== 1'b1 && g < 5000);
  endtask

  task automatic gap(input bit sel, output int g);
    bit ok;
    waitPulse(sel, ok);
    if (!ok) g = -1;
    else nextGap(sel, g);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g, g2, k, rnd, pl, ph, d, irqs;
    bit ok;
    rnd = $urandom(32'h1F2E3D4C);

    repeat (3) @(negedge clk);
    check("R1 reset pwmOut", pwmOut, 0);
    check("R1 reset loIrq", loIrq, 0);
    check("R1 reset hiIrq", hiIrq, 0);
    rstN = 1'b1;

    // stopped timer with PWM settings stays silent
    mode = 2'd1; dutyVal = 16'd100; periodVal = 16'h0303;
    irqs = 0; k = 0;
    repeat (40) begin
      @(negedge clk);
      k += pwmOut;
      irqs += loIrq + hiIrq;
    end
    check("R1 stopped pwm highs", k, 0);
    check("R1 stopped irqs", irqs, 0);

    // R4 split timers, directed then random
    setup(2'd0, 1'b1, 16'h0B05, 0, 0);
    gap(1'b0, g); check("R4 lo gap", g, 12);
    gap(1'b1, g); check("R4 hi gap", g, 24);
    countHigh(200, k); check("R10 mode0 pwm", k, 0);
    for (int i = 0; i < 4; i++) begin
      pl = 1 + ($urandom % 30);
      ph = 1 + ($urandom % 30);
      setup(2'd0, 1'b0, (ph << 8) | pl, 0, 0);
      gap(1'b0, g); check("R4 rnd lo gap", g, 2 * (pl + 1));
      gap(1'b1, g); check("R4 rnd hi gap", g, 2 * (ph + 1));
    end

    // R2 / R3 joined timer coarse versus fine
    setup(2'd2, 1'b0, 40, 0, 0);
    gap(1'b1, g); check("R2 wide coarse gap", g, 82);
    setup(2'd2, 1'b1, 40, 0, 0);
    gap(1'b1, g); check("R3 wide fine gap", g, 41);
    setup(2'd2, 1'b1, 300, 0, 0);
    gap(1'b1, g); check("R6 wide gap above byte", g, 301);
    irqs = 0; k = 0;
    repeat (400) begin
      @(negedge clk);
      irqs += loIrq;
      k += pwmOut;
    end
    check("R6 wide loIrq idle", irqs, 0);
    check("R10 mode2 pwm", k, 0);
    for (int i = 0; i < 3; i++) begin
      pl = 20 + ($urandom % 900);
      setup(2'd2, 1'(i), pl, 0, 0);
      gap(1'b1, g); check("R6 rnd wide gap", g, (i % 2) ? pl + 1 : 2 * (pl + 1));
    end

    // R5 timer plus 8-bit PWM
    setup(2'd1, 1'b1, 16'h0007, 90, 0);
    gap(1'b1, g); check("R5 pwm8 period", g, 512);
    gap(1'b0, g); check("R5 lo timer gap", g, 16);
    countHigh(512, k); check("R5 pwm8 highs", k, 180);
    for (int i = 0; i < 3; i++) begin
      d = $urandom % 256;
      setup(2'd1, 1'b0, 16'h0003, d, 0);
      countHigh(512, k); check("R5 rnd pwm8 highs", k, 2 * d);
    end
    setup(2'd1, 1'b0, 16'h0003, 255, 0);
    countHigh(512, k); check("R5 pwm8 duty max", k, 510);
    setup(2'd1, 1'b0, 16'h0003, 0, 0);
    countHigh(512, k); check("R9 pwm8 duty zero", k, 0);

    // R7 variable width PWM
    setup(2'd3, 1'b1, 0, 200, 0);
    gap(1'b1, g); check("R7 width9 period", g, 512);
    countHigh(512, k); check("R7 width9 highs", k, wideHighs(0, 200, 1));
    setup(2'd3, 1'b1, 0, 1500, 2);
    gap(1'b1, g); check("R7 width11 period", g, 2048);
    countHigh(2048, k); check("R7 width11 highs", k, wideHighs(2, 1500, 1));
    setup(2'd3, 1'b0, 0, 300, 1);
    gap(1'b1, g); check("R2 R7 width10 coarse period", g, 2048);
    countHigh(2048, k); check("R7 width10 coarse highs", k, wideHighs(1, 300, 0));
    for (int i = 0; i < 3; i++) begin
      pl = $urandom % 2;
      d = $urandom % 1200;
      setup(2'd3, 1'b1, 0, d, pl);
      countHigh(1 << (9 + pl), k);
      check("R7 rnd highs", k, wideHighs(pl, d, 1));
    end

    // R9 saturated ends
    setup(2'd3, 1'b1, 0, 0, 0);
    countHigh(512, k); check("R9 duty zero", k, 0);
    setup(2'd3, 1'b1, 0, 512, 0);
    countHigh(512, k); check("R9 duty equal period", k, 512);
    setup(2'd3, 1'b1, 0, 60000, 0);
    countHigh(512, k); check("R9 duty above period", k, 512);

    // R8 duty change held until boundary
    setup(2'd3, 1'b1, 0, 100, 0);
    waitPulse(1'b1, ok);
    check("R8 boundary seen", int'(ok), 1);
    dutyVal = 16'd300;
    k = pwmOut;
    repeat (511) begin
      @(negedge clk);
      k += pwmOut;
    end
    check("R8 old duty kept", k, 100);
    countHigh(512, k); check("R8 new duty used", k, 300);

    // R8 width change held until boundary
    waitPulse(1'b1, ok);
    widthSel = 3'd1;
    nextGap(1'b1, g);
    nextGap(1'b1, g2);
    check("R8 old width kept", g, 512);
    check("R8 new width used", g2, 1024);

    // stopping mid-run clears outputs
    @(negedge clk);
    start = 1'b0;
    dutyVal = 16'd1000;
    @(negedge clk);
    irqs = 0; k = 0;
    repeat (30) begin
      @(negedge clk);
      k += pwmOut;
      irqs += loIrq + hiIrq;
    end
    check("R1 after stop pwm", k, 0);
    check("R1 after stop irqs", irqs, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule